// File: doc/BRIEF.md
# Two-Read One-Write Processor Register File

This block is the integer register file of a pipelined processor core. It holds thirty-two 32-bit registers. It offers two read ports, which an instruction's two source operands use in the same cycle, and one write port for the result coming back from write-back. Each read port is purely combinational: the output follows its address within the same cycle, with no clock involved. The write port updates storage on the rising clock edge.

Each storage bank has only one read port. To get two, the storage is duplicated. Two identical banks sit side by side, every accepted write goes into both, and each bank serves one read port. Register 0 is hard-wired to zero. The write control drops any write aimed at it, and the read path returns zero for address 0 whatever the bank holds there. A value written at an edge can be read in the next cycle, so write-back needs no bypass network. Only the write path is affected by reset: writes are blocked while it is held, and stored values are not cleared.

Top module: `regfile_2r1w`

## Requirements
- R1: Each of registers 1 to 31 stores the last 32-bit value accepted for it. Either read port returns that value when given the register's 5-bit index.
- R2: Both read ports are combinational and independent. Changing `rdAddrA` or `rdAddrB` changes the matching output in the same cycle, with no clock edge.
- R3: A write with `wrAddr` equal to 0 is discarded. Reading address 0 on either port always returns 32'h0, including during reset.
- R4: Both storage copies receive every accepted write. The same address on both ports always gives equal data.
- R5: A write with `wrEn` = 1 and a nonzero `wrAddr` takes effect at the rising edge. The new value is visible on both ports in the cycle that follows.
- R6: When a port reads the address being written in that same cycle, it returns the old value until the edge.
- R7: With `wrEn` = 0, no register changes, whatever `wrAddr` and `wrData` hold.
- R8: While `rst_n` is low, writes are ignored. Releasing reset does not alter stored register values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes while low |
| wrEn | input | 1 | Write request |
| wrAddr | input | 5 | Index of the register to write |
| wrData | input | 32 | Value to write |
| rdAddrA | input | 5 | Index read on port A |
| rdDataA | output | 32 | Combinational read data, port A |
| rdAddrB | input | 5 | Index read on port B |
| rdDataB | output | 32 | Combinational read data, port B |

## Verification
First every register from 1 to 31 is filled with a distinct value and read back through both ports using crossed index pairs. This shows that each port decodes its own address. A vector table then mixes writes, idle cycles with junk on the write bus, writes to index 0, and reads that hit the register being written both before and after the edge. These separate the old value from the new one and separate a suppressed write from a taken one. Pseudo-random writes, each followed by reading one index on both ports, expose any write that reached only one copy. A reset pulse with a pending write checks that writes are blocked and that stored data survives.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  // Number of read ports; each one is served by its own storage copy.
  localparam int NUM_RD = 2;

  // Strobes passed from the write/read control to the datapath.
  typedef struct packed {
    logic              bankWe;   // commit the write into every bank
    logic [NUM_RD-1:0] rdZero;   // force the read result of a port to zero
  } rfStrobe_t;

endpackage

// File: rtl/regfile_ctrl.sv
module regfile_ctrl
  import regfile_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                          rst_n,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddr,
  output rfStrobe_t                     strb
);

  localparam logic [ADDR_W-1:0] ZERO_IDX = '0;

  logic wrAddrLive;

  // A write only counts when it targets a real register and reset is off.
  assign wrAddrLive  = (wrAddr != ZERO_IDX);
  assign strb.bankWe = rst_n & wrEn & wrAddrLive;

  // Register 0 reads are resolved by control, not by bank contents.
  for (genvar p = 0; p < NUM_RD; p++) begin : g_zero
    assign strb.rdZero[p] = (rdAddr[p] == ZERO_IDX);
  end

endmodule

// File: rtl/regfile_bank.sv
module regfile_bank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rd
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  // Synchronous write port.
  always_ff @(posedge clk) begin
    if (we) store[wa] <= wd;
  end

  // Asynchronous read port.
  assign rd = store[ra];

endmodule

// File: rtl/regfile_dp.sv
module regfile_dp
  import regfile_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  rfStrobe_t                     strb,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddr,
  output logic [NUM_RD-1:0][DATA_W-1:0] rdData
);

  logic [NUM_RD-1:0][DATA_W-1:0] bankOut;

  // One replica per read port; all replicas share the write port.
  for (genvar p = 0; p < NUM_RD; p++) begin : g_bank
    regfile_bank #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
    ) u_bank (
      .clk(clk),
      .we (strb.bankWe),
      .wa (wrAddr),
      .wd (wrData),
      .ra (rdAddr[p]),
      .rd (bankOut[p])
    );
    assign rdData[p] = strb.rdZero[p] ? '0 : bankOut[p];
  end

  // Two replicas read at one index must agree (once that index was written).
  p_banks_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddr[0] == rdAddr[1] && !$isunknown(rdData[0]))
      |-> rdData[0] == rdData[1]);

  // With no accepted write, a held address keeps its data on each port.
  p_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rdAddr[0]) && !$past(strb.bankWe)) |-> $stable(rdData[0]));
  p_hold_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rdAddr[1]) && !$past(strb.bankWe)) |-> $stable(rdData[1]));

endmodule

// File: rtl/regfile_2r1w.sv
module regfile_2r1w
  import regfile_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB
);

  rfStrobe_t                     strb;
  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddr;
  logic [NUM_RD-1:0][DATA_W-1:0] rdData;

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  regfile_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .rst_n (rst_n),
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .strb  (strb)
  );

  regfile_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .strb  (strb),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );

  // A port reading register 0 always sees zero.
  p_zero_read_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdAddrA == '0 |-> rdDataA == '0);
  p_zero_read_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdAddrB == '0 |-> rdDataB == '0);

  // A taken write is readable on both ports in the following cycle.
  p_write_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr != '0) |=>
      ((rdAddrA != $past(wrAddr)) || (rdDataA == $past(wrData))) &&
      ((rdAddrB != $past(wrAddr)) || (rdDataB == $past(wrData))));

endmodule

// File: tb/regfile_2r1w_test.sv
module regfile_2r1w_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wrEn;
  logic [4:0]  wrAddr;
  logic [31:0] wrData;
  logic [4:0]  rdAddrA;
  logic [31:0] rdDataA;
  logic [4:0]  rdAddrB;
  logic [31:0] rdDataB;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] model [32];

  regfile_2r1w uut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB)
  );

  always #4 clk = ~clk;

  // Vector layout: {wrEn, wrAddr, rdAddrA, rdAddrB, wrData}
  localparam int NVEC = 12;
  localparam logic [47:0] VEC [NVEC] = '{
    {1'b1, 5'd3,  5'd3,  5'd4,  32'hDEADBEEF},  // R6 read old value of 3
    {1'b0, 5'd3,  5'd3,  5'd3,  32'h00000000},  // R5 new value of 3
    {1'b1, 5'd0,  5'd0,  5'd3,  32'hFFFFFFFF},  // R3 write to 0
    {1'b0, 5'd0,  5'd0,  5'd0,  32'h00000000},  // R3 zero kept
    {1'b0, 5'd9,  5'd9,  5'd9,  32'h12345678},  // R7 idle with junk
    {1'b0, 5'd0,  5'd9,  5'd31, 32'h00000000},  // R7 9 unchanged
    {1'b1, 5'd31, 5'd31, 5'd1,  32'hCAFEF00D},
    {1'b1, 5'd1,  5'd31, 5'd1,  32'h0BADC0DE},
    {1'b1, 5'd1,  5'd1,  5'd1,  32'h11111111},  // R6 old 0BADC0DE
    {1'b0, 5'd0,  5'd1,  5'd31, 32'h00000000},
    {1'b1, 5'd16, 5'd16, 5'd15, 32'h80000001},
    {1'b0, 5'd0,  5'd16, 5'd0,  32'h00000000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Drive at the falling edge; the following rising edge commits.
  task automatic drive(input logic en, input logic [4:0] wa, input logic [31:0] wd,
                       input logic [4:0] ra, input logic [4:0] rb);
    @(negedge clk);
    wrEn = en; wrAddr = wa; wrData = wd; rdAddrA = ra; rdAddrB = rb;
    #1;
  endtask

  function automatic logic [31:0] exp(input logic [4:0] a);
    return (a == 5'd0) ? 32'h0 : model[a];
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        finishRun();
      end
    end
  end

  initial begin
    logic [31:0] lfsr;
    rst_n = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddrA = '0; rdAddrB = '0;
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    #1;
    check("R3 reset zero port A", rdDataA, 32'h0);
    check("R3 reset zero port B", rdDataB, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: fill every register, then read back with crossed indices.
    for (int i = 1; i < 32; i++) begin
      drive(1'b1, 5'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101), 5'd0, 5'd0);
      model[i] = 32'hA5000000 ^ (32'(i) * 32'h01010101);
    end
    drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    for (int i = 0; i < 32; i++) begin
      drive(1'b0, 5'd0, 32'h0, 5'(i), 5'(31 - i));
      check("R1 fill port A", rdDataA, exp(5'(i)));
      check("R1 fill port B", rdDataB, exp(5'(31 - i)));
    end

    // Table of directed vectors (R3, R5, R6, R7).
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v][47], VEC[v][46:42], VEC[v][31:0], VEC[v][41:37], VEC[v][36:32]);
      check("R5/R6/R3/R7 table port A", rdDataA, exp(VEC[v][41:37]));
      check("R5/R6/R3/R7 table port B", rdDataB, exp(VEC[v][36:32]));
      if (VEC[v][47] && VEC[v][46:42] != 5'd0) model[VEC[v][46:42]] = VEC[v][31:0];
    end

    // R4: random writes, then the same index on both ports.
    lfsr = 32'h1ACE1ACE;
    for (int n = 0; n < 40; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      drive(1'b1, lfsr[4:0], lfsr ^ 32'h5A5A5A5A, lfsr[9:5], lfsr[9:5]);
      if (lfsr[4:0] != 5'd0) model[lfsr[4:0]] = lfsr ^ 32'h5A5A5A5A;
      drive(1'b0, 5'd0, 32'h0, lfsr[4:0], lfsr[4:0]);
      check("R4 copies agree", rdDataA, rdDataB);
      check("R4 copy value", rdDataB, exp(lfsr[4:0]));
    end

    // R2: address changes without any clock edge.
    @(negedge clk);
    wrEn = 1'b0; rdAddrA = 5'd5; rdAddrB = 5'd6;
    #1;
    check("R2 port A comb", rdDataA, exp(5'd5));
    check("R2 port B comb", rdDataB, exp(5'd6));
    rdAddrA = 5'd6; rdAddrB = 5'd5;
    #1;
    check("R2 port A follows", rdDataA, exp(5'd6));
    check("R2 port B follows", rdDataB, exp(5'd5));

    // R8: a write held during reset is ignored; data survives reset.
    @(negedge clk);
    rst_n = 1'b0;
    wrEn = 1'b1; wrAddr = 5'd7; wrData = 32'h77777777; rdAddrA = 5'd7; rdAddrB = 5'd8;
    repeat (2) @(negedge clk);
    wrEn = 1'b0;
    rst_n = 1'b1;
    #1;
    check("R8 write blocked in reset", rdDataA, exp(5'd7));
    check("R8 data kept over reset", rdDataB, exp(5'd8));

    drive(1'b0, 5'd0, 32'h0, 5'd0, 5'd0);
    finishRun();
  end

endmodule